// File: doc/BRIEF.md
# CPU Clock Mux and Divider Control Registers

This block is the register view of a CPU-domain clock tree: one source select (main PLL or an alternate source), two divider-ratio registers, and the status registers a controller polls while a change settles. It drives no real clock and does no glitch-free switching. It only keeps the programmed values and produces status timing that a rate-change sequence must respect.

Software or a hardware sequencer reaches the block over a simple single-cycle address/data bus. A typical rate change selects the alternate source and polls the mux status until it reports that source. It then writes new divider ratios and polls each divider status until its busy bits clear, and finally switches back to the PLL and polls again. Changing a ratio field arms a per-field settle counter. Changing the select arms a mux settle counter that makes the status read "in transition" before it reports the new source.

Top module: `clkreg_top`

## Requirements
- R1: After reset, every register reads zero except the mux status, which reads 0x0001_0000 (PLL selected, settled).
- R2: The select register at offset 0x200 stores only bit 16 (1 = alternate source, 0 = PLL). All other bits read zero, and `alt_sel_o` follows bit 16.
- R3: The mux status at offset 0x400 carries a 3-bit code in bits [18:16]: 1 = PLL, 2 = alternate, 4 = in transition. After a write that changes bit 16, the code reads 4 for MUX_SETTLE reads in a row and then shows the new source. A further change during the transition restarts the count.
- R4: Writing the select with the bit 16 value it already holds starts no transition.
- R5: The divider registers at 0x500 and 0x504 each hold NUM_FIELDS ratio fields of FIELD_W = 3 bits, with field k at bits [4k+2:4k]. The core ratio is field 0, bits [2:0], and the debug-bus ratio is field 4, bits [18:16]. All other bits read zero.
- R6: The divider status registers at 0x600 (for 0x500) and 0x604 (for 0x504) have a busy bit at bit 4k for field k. After a write that changes field k, that bit reads 1 for DIV_SETTLE reads in a row and then reads 0.
- R7: A divider write leaves the busy bit of every field whose value it does not change untouched. Each field settles on its own.
- R8: A write that changes a field while its busy bit is set restarts that field's full settle period.
- R9: Reads of any offset other than the six listed return zero. Writes to the mux status, the divider status or unmapped offsets change no register.
- R10: A read request (`bus_en` high, `bus_we` low) is answered on the next cycle with `bus_rvalid` high and the data on `bus_rdata`. Writes and idle cycles leave `bus_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid (one cycle after request) |
| alt_sel_o | output | 1 | Current source select, 1 = alternate |
| div0_o | output | 32 | Divider register 0 contents |
| div1_o | output | 32 | Divider register 1 contents |

## Verification
Two events can land on the same clock edge: a field's settle counter expiring and a new write that changes the same field. The mux has the same collision between the end of its transition and a new select change. Directed writes are timed to arrive exactly on the last busy cycle and just after it. The random phase issues back-to-back writes of near-identical data, so changed and unchanged fields are mixed in one access. Every read is compared against a cycle-level bench model of the counters. That model must show the restart (busy or "in transition" continues for a full period) rather than a single idle read in between.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SEL   = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_DIV0  = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_DIV1  = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_DST0  = 12'h600;
  localparam logic [ADDR_W-1:0] OFS_DST1  = 12'h604;

  localparam int unsigned SEL_BIT   = 16;
  localparam int unsigned MSTAT_LSB = 16;

  typedef enum logic [2:0] {
    MST_PLL    = 3'd1,
    MST_ALT    = 3'd2,
    MST_MOVING = 3'd4
  } mux_stat_e;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_SEL,
    RS_MSTAT,
    RS_DIV0,
    RS_DIV1,
    RS_DST0,
    RS_DST1
  } reg_hit_e;
endpackage

// File: rtl/clkreg_bus_dec.sv
module clkreg_bus_dec
  import clkreg_pkg::*;
(
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_hit_e          hit,
  output logic              wr_sel,
  output logic [1:0]        wr_div
);
  always_comb begin
    hit = RS_NONE;
    if (bus_en) begin
      unique case (bus_addr)
        OFS_SEL:   hit = RS_SEL;
        OFS_MSTAT: hit = RS_MSTAT;
        OFS_DIV0:  hit = RS_DIV0;
        OFS_DIV1:  hit = RS_DIV1;
        OFS_DST0:  hit = RS_DST0;
        OFS_DST1:  hit = RS_DST1;
        default:   hit = RS_NONE;
      endcase
    end
  end

  // status offsets and unmapped offsets produce no write strobe
  assign wr_sel    = bus_we && (hit == RS_SEL);
  assign wr_div[0] = bus_we && (hit == RS_DIV0);
  assign wr_div[1] = bus_we && (hit == RS_DIV1);
endmodule

// File: rtl/clkreg_mux_ctl.sv
module clkreg_mux_ctl
  import clkreg_pkg::*;
#(
  parameter int unsigned SETTLE = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      want_alt,
  output logic      alt_q,
  output mux_stat_e stat_q
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);

  logic             alt_r;
  logic [CNT_W-1:0] cnt_r;
  logic             flip;

  assign flip = wr_en && (want_alt != alt_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alt_r <= 1'b0;
      cnt_r <= '0;
    end else begin
      if (wr_en) alt_r <= want_alt;
      if (flip)              cnt_r <= CNT_W'(SETTLE);
      else if (cnt_r != '0)  cnt_r <= cnt_r - 1'b1;
    end
  end

  always_comb begin
    if (cnt_r != '0)  stat_q = MST_MOVING;
    else if (alt_r)   stat_q = MST_ALT;
    else              stat_q = MST_PLL;
  end

  assign alt_q = alt_r;
endmodule

// File: rtl/clkreg_div_bank.sv
module clkreg_div_bank
  import clkreg_pkg::*;
#(
  parameter int unsigned NUM_FIELDS   = 8,
  parameter int unsigned FIELD_W      = 3,
  parameter int unsigned FIELD_STRIDE = 4,
  parameter int unsigned SETTLE       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ratio_q,
  output logic [DATA_W-1:0] busy_q
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] ratio_arr;
  logic [NUM_FIELDS-1:0]              busy_arr;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    localparam int unsigned LSB = k * FIELD_STRIDE;

    logic [FIELD_W-1:0] ratio_r;
    logic [CNT_W-1:0]   cnt_r;
    logic               changed;

    assign changed = wr_en && (wdata[LSB +: FIELD_W] != ratio_r);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ratio_r <= '0;
        cnt_r   <= '0;
      end else begin
        if (wr_en) ratio_r <= wdata[LSB +: FIELD_W];
        if (changed)           cnt_r <= CNT_W'(SETTLE);
        else if (cnt_r != '0)  cnt_r <= cnt_r - 1'b1;
      end
    end

    assign ratio_arr[k] = ratio_r;
    assign busy_arr[k]  = (cnt_r != '0);
  end

  always_comb begin
    ratio_q = '0;
    busy_q  = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      ratio_q[k*FIELD_STRIDE +: FIELD_W] = ratio_arr[k];
      busy_q[k*FIELD_STRIDE]             = busy_arr[k];
    end
  end
endmodule

// File: rtl/clkreg_top.sv
module clkreg_top
  import clkreg_pkg::*;
#(
  parameter int unsigned NUM_FIELDS   = 8,
  parameter int unsigned FIELD_W      = 3,
  parameter int unsigned FIELD_STRIDE = 4,
  parameter int unsigned DIV_SETTLE   = 6,
  parameter int unsigned MUX_SETTLE   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        alt_sel_o,
  output logic [31:0] div0_o,
  output logic [31:0] div1_o
);
  localparam int unsigned NUM_BANKS = 2;

  reg_hit_e                              hit;
  logic                                  wr_sel;
  logic [NUM_BANKS-1:0]                  wr_div;
  mux_stat_e                             mux_stat;
  logic                                  alt_q;
  logic [NUM_BANKS-1:0][DATA_W-1:0]      ratio;
  logic [NUM_BANKS-1:0][DATA_W-1:0]      busy;
  logic [DATA_W-1:0]                     dst0_q;
  logic [DATA_W-1:0]                     rd_mux;

  clkreg_bus_dec u_dec (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .hit      (hit),
    .wr_sel   (wr_sel),
    .wr_div   (wr_div)
  );

  clkreg_mux_ctl #(.SETTLE(MUX_SETTLE)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_sel),
    .want_alt (bus_wdata[SEL_BIT]),
    .alt_q    (alt_q),
    .stat_q   (mux_stat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkreg_div_bank #(
      .NUM_FIELDS   (NUM_FIELDS),
      .FIELD_W      (FIELD_W),
      .FIELD_STRIDE (FIELD_STRIDE),
      .SETTLE       (DIV_SETTLE)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_div[b]),
      .wdata   (bus_wdata),
      .ratio_q (ratio[b]),
      .busy_q  (busy[b])
    );
  end

  assign dst0_q = busy[0];

  always_comb begin
    rd_mux = '0;
    unique case (hit)
      RS_SEL:   rd_mux[SEL_BIT] = alt_q;
      RS_MSTAT: rd_mux[MSTAT_LSB +: 3] = mux_stat;
      RS_DIV0:  rd_mux = ratio[0];
      RS_DIV1:  rd_mux = ratio[1];
      RS_DST0:  rd_mux = busy[0];
      RS_DST1:  rd_mux = busy[1];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      if (bus_en && !bus_we) bus_rdata <= rd_mux;
    end
  end

  assign alt_sel_o = alt_q;
  assign div0_o    = ratio[0];
  assign div1_o    = ratio[1];
endmodule

// File: rtl/clkreg_sva.sv
module clkreg_sva
  import clkreg_pkg::*;
#(
  parameter int unsigned FIELD_W = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_rvalid,
  input logic        alt_sel_o,
  input logic [31:0] div0_o,
  input logic [2:0]  mux_stat,
  input logic [31:0] div0_busy
);
  logic rd_req, wr_req;
  assign rd_req = bus_en && !bus_we;
  assign wr_req = bus_en && bus_we;

  // R10: a read is answered on the next cycle
  a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  // R10: no answer without a read
  a_r10_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  // R3: the status code is always one of the three legal codes
  a_r3_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mux_stat) == 1);
  // R3: once settled, the status agrees with the select
  a_r3_settled_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_stat != 3'd4) |-> (mux_stat == (alt_sel_o ? 3'd2 : 3'd1)));
  // R3: changing the select enters the transition state
  a_r3_change_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == OFS_SEL && bus_wdata[SEL_BIT] != alt_sel_o) |=> (mux_stat == 3'd4));

  // R4: rewriting the held select while settled keeps the status
  a_r4_same_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == OFS_SEL && bus_wdata[SEL_BIT] == alt_sel_o && mux_stat != 3'd4)
    |=> $stable(mux_stat));

  // R6: changing the core field makes it busy
  a_r6_busy_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == OFS_DIV0 && bus_wdata[FIELD_W-1:0] != div0_o[FIELD_W-1:0])
    |=> div0_busy[0]);

  // R7: an unchanged idle field stays idle
  a_r7_same_field_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == OFS_DIV0 && bus_wdata[FIELD_W-1:0] == div0_o[FIELD_W-1:0] && !div0_busy[0])
    |=> !div0_busy[0]);

  // R9: status-register writes touch no stored value
  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (bus_addr == OFS_MSTAT || bus_addr == OFS_DST0 || bus_addr == OFS_DST1))
    |=> ($stable(div0_o) && $stable(alt_sel_o)));
endmodule

bind clkreg_top clkreg_sva #(.FIELD_W(FIELD_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .alt_sel_o  (alt_sel_o),
  .div0_o     (div0_o),
  .mux_stat   (mux_stat),
  .div0_busy  (dst0_q)
);

// File: tb/clkreg_top_tb_top.sv
`timescale 1ns/1ps
module clkreg_top_tb_top;
  localparam int NF = 8;
  localparam int FW = 3;
  localparam int FS = 4;
  localparam int DS = 6;
  localparam int MS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        alt_sel_o;
  logic [31:0] div0_o;
  logic [31:0] div1_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkreg_top #(
    .NUM_FIELDS(NF), .FIELD_W(FW), .FIELD_STRIDE(FS),
    .DIV_SETTLE(DS), .MUX_SETTLE(MS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .alt_sel_o(alt_sel_o),
    .div0_o(div0_o), .div1_o(div1_o)
  );

  // bench model of the programmer-visible state
  logic [FW-1:0] m_ratio [2][NF];
  int            m_cnt   [2][NF];
  bit            m_alt;
  int            m_mcnt;

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < NF; k++) begin
        m_ratio[b][k] = '0;
        m_cnt[b][k] = 0;
      end
    m_alt = 0;
    m_mcnt = 0;
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] v = '0;
    case (a)
      12'h200: v[16] = m_alt;
      12'h400: v[18:16] = (m_mcnt != 0) ? 3'd4 : (m_alt ? 3'd2 : 3'd1);
      12'h500: for (int k = 0; k < NF; k++) v[k*FS +: FW] = m_ratio[0][k];
      12'h504: for (int k = 0; k < NF; k++) v[k*FS +: FW] = m_ratio[1][k];
      12'h600: for (int k = 0; k < NF; k++) v[k*FS] = (m_cnt[0][k] != 0);
      12'h604: for (int k = 0; k < NF; k++) v[k*FS] = (m_cnt[1][k] != 0);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_step(bit en, bit we, logic [11:0] a, logic [31:0] d);
    bit wsel = en && we && (a == 12'h200);
    for (int b = 0; b < 2; b++) begin
      bit wd = en && we && (a == (b == 0 ? 12'h500 : 12'h504));
      for (int k = 0; k < NF; k++) begin
        if (wd && d[k*FS +: FW] != m_ratio[b][k]) begin
          m_ratio[b][k] = d[k*FS +: FW];
          m_cnt[b][k] = DS;
        end else if (m_cnt[b][k] != 0) begin
          m_cnt[b][k] = m_cnt[b][k] - 1;
        end
      end
    end
    if (wsel && d[16] != m_alt) begin
      m_alt = d[16];
      m_mcnt = MS;
    end else if (m_mcnt != 0) begin
      m_mcnt = m_mcnt - 1;
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h200: return "R2";
      12'h400: return "R3";
      12'h500, 12'h504: return "R5";
      12'h600, 12'h604: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; entered and left at a falling edge
  task automatic op(bit en, bit we, logic [11:0] a, logic [31:0] d, string req);
    logic [31:0] exp = model_read(a);
    bit rd = en && !we;
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(en, we, a, d);
    @(negedge clk);
    bus_en = 1'b0;
    if (rd) begin
      chk("R10", {31'd0, bus_rvalid}, 32'd1);
      chk(req, bus_rdata, exp);
    end else begin
      chk("R10", {31'd0, bus_rvalid}, 32'd0);
    end
  endtask

  task automatic rd(logic [11:0] a, string req);
    op(1, 0, a, '0, req);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string req);
    op(1, 1, a, d, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(12'h400, "R1");
    chk("R1", bus_rdata, 32'h0001_0000);
    rd(12'h200, "R1");
    rd(12'h500, "R1");
    rd(12'h504, "R1");
    rd(12'h600, "R1");
    rd(12'h604, "R1");

    // R2: only bit 16 is stored
    wr(12'h200, 32'hFFFF_FFFF, "R2");
    rd(12'h400, "R3");
    chk("R3", bus_rdata, 32'h0004_0000);
    rd(12'h200, "R2");
    chk("R2", bus_rdata, 32'h0001_0000);
    for (int i = 0; i < MS + 1; i++) rd(12'h400, "R3");
    chk("R3", bus_rdata, 32'h0002_0000);

    // R4: same value again leaves status settled
    wr(12'h200, 32'h0001_0000, "R4");
    rd(12'h400, "R4");
    chk("R4", bus_rdata, 32'h0002_0000);

    // R3: restart on a change landing on the last transition cycle
    wr(12'h200, 32'h0, "R3");
    for (int i = 0; i < MS - 1; i++) op(0, 0, '0, '0, "R3");
    wr(12'h200, 32'h0001_0000, "R3");
    for (int i = 0; i < MS + 1; i++) rd(12'h400, "R3");

    // R5: field layout, core and debug fields
    wr(12'h500, 32'hFFFF_FFFF, "R5");
    rd(12'h500, "R5");
    chk("R5", bus_rdata, 32'h7777_7777);
    for (int i = 0; i < DS + 1; i++) rd(12'h600, "R6");
    wr(12'h500, 32'h0005_0003, "R5");
    rd(12'h500, "R5");
    chk("R5", bus_rdata, 32'h0005_0003);
    rd(12'h600, "R6");
    chk("R6", bus_rdata, 32'h1111_1111);
    for (int i = 0; i < DS; i++) rd(12'h600, "R6");
    chk("R6", bus_rdata, 32'h0);

    // R7: unchanged fields stay idle, one field changed
    wr(12'h500, 32'h0005_0013, "R7");
    rd(12'h600, "R7");
    chk("R7", bus_rdata, 32'h0000_0010);
    wr(12'h504, 32'h0, "R7");
    rd(12'h604, "R7");
    chk("R7", bus_rdata, 32'h0);

    // R8: change exactly on the last busy cycle restarts the period
    for (int i = 0; i < DS; i++) op(0, 0, '0, '0, "R8");
    wr(12'h504, 32'h0000_0002, "R8");
    for (int i = 0; i < DS - 1; i++) op(0, 0, '0, '0, "R8");
    wr(12'h504, 32'h0000_0004, "R8");
    for (int i = 0; i < DS + 1; i++) rd(12'h604, "R8");

    // R9: ignored writes and unmapped reads
    wr(12'h400, 32'hFFFF_FFFF, "R9");
    wr(12'h600, 32'hFFFF_FFFF, "R9");
    wr(12'h604, 32'hFFFF_FFFF, "R9");
    wr(12'h508, 32'hFFFF_FFFF, "R9");
    rd(12'h500, "R9");
    rd(12'h504, "R9");
    rd(12'h200, "R9");
    rd(12'h400, "R9");
    rd(12'h000, "R9");
    rd(12'h204, "R9");
    rd(12'h508, "R9");
    chk("R9", bus_rdata, 32'h0);
    rd(12'hFFC, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] addrs [10] = '{12'h200, 12'h400, 12'h500, 12'h504, 12'h600,
                                  12'h604, 12'h500, 12'h600, 12'h0FC, 12'h404};
      logic [11:0] a = addrs[$urandom_range(0, 9)];
      bit en = ($urandom_range(0, 7) != 0);
      bit we = ($urandom_range(0, 2) == 0);
      logic [31:0] d = $urandom & ($urandom_range(0, 1) ? 32'h0001_0011 : 32'hFFFF_FFFF);
      op(en, we, a, d, tag_of(a));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule